// File: doc/BRIEF.md
# Radix Page Table Walker

This block turns a virtual address into a final page-table entry by reading a four-level radix table held in memory. A translation cache raises a request with the virtual address; the walker reads one eight-byte entry per level, starting from the table root held in its base register, and follows pointer entries downward until it finds a leaf, an invalid entry, or the bottom level. It then returns the entry it found on a one-cycle response.

Each level takes nine bits of the virtual address, with the most significant group used first. Entry reads leave through a simple read port: a one-cycle address strobe out, and 64-bit data with a valid flag back. Only one read is outstanding at a time. The walker never reads at or beyond a configured memory size. When translation is switched off, it builds an identity-mapped entry at once and makes no memory reads.

Entry layout, used both in memory and on the response: bit 0 valid, bit 1 leaf, bit 2 referenced, bit 3 dirty, bits 9:4 the six permission flags, bits 11:10 zero, and bits 63:12 the physical page number.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `resp_valid` and `mem_rd_valid` are 0.
- R2: A write to the base register stores the written value with bits 11:0 cleared.
- R3: At level L (3 first, down to 0) the entry is read from base + 8 * ((vaddr >> (12 + 9*L)) & 511). The level-3 base is the base register. Each later base is the physical page number (bits 63:12) of the entry just read, shifted left by 12.
- R4: If an entry address is greater than or equal to `mem_size`, the walk stops without reading that address and responds with an all-zero entry.
- R5: A read entry with bit 0 clear ends the walk. The response is that entry unchanged, with bit 0 still clear.
- R6: A read entry with bits 0 and 1 both set ends the walk. The response is that entry unchanged.
- R7: If the level-0 entry is valid but not a leaf, the walk ends after exactly four reads. The response is that entry with bit 0 cleared.
- R8: With `xlate_en` low at acceptance, no memory read is made. The response has bits 63:12 = vaddr[63:12], bits 9:4 all ones, bit 1 set, bits 11:10 and 3:2 clear, and bit 0 = (vaddr < `mem_size`).
- R9: A request is accepted only while `req_ready` is high. `req_ready` falls in the cycle after acceptance. Each accepted request gets exactly one single-cycle `resp_valid` pulse.
- R10: A walk uses the base register value held when the request is accepted. A base write in the same cycle as acceptance, or during the walk, affects only later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_wr_en | input | 1 | Write strobe for the table base register |
| base_wr_data | input | 64 | Value written to the base register |
| xlate_en | input | 1 | Translation on (1) or identity bypass (0) |
| mem_size | input | 64 | Size of physical memory in bytes |
| req_valid | input | 1 | Walk request strobe |
| req_vaddr | input | 64 | Virtual address to resolve |
| req_ready | output | 1 | Walker idle and able to accept a request |
| resp_valid | output | 1 | One-cycle result strobe |
| resp_pte | output | 64 | Resulting entry |
| mem_rd_valid | output | 1 | One-cycle read strobe |
| mem_rd_addr | output | 64 | Byte address of the entry read |
| mem_rd_data_valid | input | 1 | Read data is present |
| mem_rd_data | input | 64 | Entry read from memory |

## Verification
A base register write and a request acceptance can happen on the same clock edge. A base write can also arrive while a walk is in progress. The bench provokes both cases. It writes a second table root in the same cycle it raises a request, and again a few cycles into a four-level walk. It then checks that every read address and the response still come from the old table, and that the next request follows the new one. The scoreboard derives its expected entries and read addresses from a bench model of the table. It flags any read the model did not predict.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int PTE_V_BIT    = 0;
  localparam int PTE_LEAF_BIT = 1;
  localparam int PTE_REF_BIT  = 2;
  localparam int PTE_DRT_BIT  = 3;
  localparam int PTE_PERM_LO  = 4;
  localparam int PTE_PERM_W   = 6;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } walk_state_e;
endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
  parameter int XLEN     = 64,
  parameter int PG_SHIFT = 12,
  parameter int PTE_LG   = 3,
  parameter int LEVELS   = 4,
  parameter int LVL_W    = 2
) (
  input  logic [XLEN-1:0]  base,
  input  logic [XLEN-1:0]  vaddr,
  input  logic [LVL_W-1:0] level,
  input  logic [XLEN-1:0]  mem_size,
  output logic [XLEN-1:0]  entry_addr,
  output logic             out_of_range
);
  localparam int IDX_W = PG_SHIFT - PTE_LG;

  logic [IDX_W-1:0] idx_by_level [LEVELS];
  logic [IDX_W-1:0] idx_sel;

  // one index slice per level
  for (genvar g = 0; g < LEVELS; g++) begin : g_slice
    assign idx_by_level[g] = vaddr[PG_SHIFT + IDX_W*g +: IDX_W];
  end

  always_comb begin
    idx_sel = '0;
    for (int k = 0; k < LEVELS; k++) begin
      if (level == LVL_W'(k)) idx_sel = idx_by_level[k];
    end
  end

  assign entry_addr   = base + (XLEN'(idx_sel) << PTE_LG);
  assign out_of_range = (entry_addr >= mem_size);
endmodule

// File: rtl/ptw_pte_eval.sv
module ptw_pte_eval #(
  parameter int XLEN     = 64,
  parameter int PG_SHIFT = 12
) (
  input  logic [XLEN-1:0] rd_data,
  input  logic            last_level,
  output logic            stop,
  output logic [XLEN-1:0] result,
  output logic [XLEN-1:0] next_base
);
  import ptw_pkg::*;

  logic ent_v;
  logic ent_leaf;

  assign ent_v    = rd_data[PTE_V_BIT];
  assign ent_leaf = rd_data[PTE_LEAF_BIT];
  assign stop     = !ent_v || ent_leaf || last_level;

  always_comb begin
    result            = rd_data;
    result[PTE_V_BIT] = ent_v && ent_leaf;
  end

  assign next_base = {rd_data[XLEN-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
endmodule

// File: rtl/ptw_identity.sv
module ptw_identity #(
  parameter int XLEN     = 64,
  parameter int PG_SHIFT = 12
) (
  input  logic [XLEN-1:0] vaddr,
  input  logic [XLEN-1:0] mem_size,
  output logic [XLEN-1:0] pte
);
  import ptw_pkg::*;

  always_comb begin
    pte = '0;
    pte[XLEN-1:PG_SHIFT] = vaddr[XLEN-1:PG_SHIFT];
    pte[PTE_PERM_LO +: PTE_PERM_W] = '1;
    pte[PTE_LEAF_BIT] = 1'b1;
    pte[PTE_REF_BIT]  = 1'b0;
    pte[PTE_DRT_BIT]  = 1'b0;
    pte[PTE_V_BIT]    = (vaddr < mem_size);
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int XLEN     = 64,
  parameter int PG_SHIFT = 12,
  parameter int PTE_LG   = 3,
  parameter int LEVELS   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            base_wr_en,
  input  logic [XLEN-1:0] base_wr_data,
  input  logic            xlate_en,
  input  logic [XLEN-1:0] mem_size,
  input  logic            req_valid,
  input  logic [XLEN-1:0] req_vaddr,
  output logic            req_ready,
  output logic            resp_valid,
  output logic [XLEN-1:0] resp_pte,
  output logic            mem_rd_valid,
  output logic [XLEN-1:0] mem_rd_addr,
  input  logic            mem_rd_data_valid,
  input  logic [XLEN-1:0] mem_rd_data
);
  import ptw_pkg::*;

  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam int CNT_W = LVL_W + 1;

  walk_state_e     state;
  logic [XLEN-1:0] tbl_base;
  logic [XLEN-1:0] walk_base;
  logic [XLEN-1:0] vaddr_q;
  logic [LVL_W-1:0] level;
  logic            xlate_q;

  logic [XLEN-1:0] ent_addr;
  logic            ent_oob;
  logic            ev_stop;
  logic [XLEN-1:0] ev_result;
  logic [XLEN-1:0] ev_next_base;
  logic [XLEN-1:0] ident_pte;
  logic            accept;

  assign accept = req_valid && req_ready;

  ptw_entry_addr #(
    .XLEN(XLEN), .PG_SHIFT(PG_SHIFT), .PTE_LG(PTE_LG),
    .LEVELS(LEVELS), .LVL_W(LVL_W)
  ) u_addr (
    .base(walk_base), .vaddr(vaddr_q), .level(level),
    .mem_size(mem_size), .entry_addr(ent_addr), .out_of_range(ent_oob)
  );

  ptw_pte_eval #(.XLEN(XLEN), .PG_SHIFT(PG_SHIFT)) u_eval (
    .rd_data(mem_rd_data), .last_level(level == '0),
    .stop(ev_stop), .result(ev_result), .next_base(ev_next_base)
  );

  ptw_identity #(.XLEN(XLEN), .PG_SHIFT(PG_SHIFT)) u_ident (
    .vaddr(req_vaddr), .mem_size(mem_size), .pte(ident_pte)
  );

  // table root register, page aligned
  always_ff @(posedge clk) begin
    if (rst)             tbl_base <= '0;
    else if (base_wr_en) tbl_base <= {base_wr_data[XLEN-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      req_ready    <= 1'b1;
      resp_valid   <= 1'b0;
      resp_pte     <= '0;
      mem_rd_valid <= 1'b0;
      mem_rd_addr  <= '0;
      walk_base    <= '0;
      vaddr_q      <= '0;
      level        <= '0;
      xlate_q      <= 1'b0;
    end else begin
      mem_rd_valid <= 1'b0;
      resp_valid   <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            req_ready <= 1'b0;
            vaddr_q   <= req_vaddr;
            xlate_q   <= xlate_en;
            walk_base <= tbl_base;
            level     <= LVL_W'(LEVELS - 1);
            if (xlate_en) begin
              state <= ST_ISSUE;
            end else begin
              resp_pte   <= ident_pte;
              resp_valid <= 1'b1;
              state      <= ST_RESP;
            end
          end
        end
        ST_ISSUE: begin
          if (ent_oob) begin
            resp_pte   <= '0;
            resp_valid <= 1'b1;
            state      <= ST_RESP;
          end else begin
            mem_rd_addr  <= ent_addr;
            mem_rd_valid <= 1'b1;
            state        <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (mem_rd_data_valid) begin
            if (ev_stop) begin
              resp_pte   <= ev_result;
              resp_valid <= 1'b1;
              state      <= ST_RESP;
            end else begin
              walk_base <= ev_next_base;
              level     <= level - 1'b1;
              state     <= ST_ISSUE;
            end
          end
        end
        ST_RESP: begin
          req_ready <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // reads issued in the current walk, for the checks below
  logic [CNT_W-1:0] rd_cnt;
  always_ff @(posedge clk) begin
    if (rst || accept)     rd_cnt <= '0;
    else if (mem_rd_valid) rd_cnt <= rd_cnt + 1'b1;
  end

  a_r9_single_resp: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);

  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  a_r9_no_resp_while_ready: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !resp_valid);

  a_r4_read_in_range: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid |-> (mem_rd_addr < mem_size));

  a_r3_read_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid |-> (mem_rd_addr[PTE_LG-1:0] == '0));

  a_r8_no_read_in_bypass: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && !xlate_q) |-> !mem_rd_valid);

  a_r7_read_limit: assert property (@(posedge clk) disable iff (rst)
    rd_cnt <= CNT_W'(LEVELS));
endmodule

// File: tb/ptw_walker_bench.sv
module ptw_walker_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        base_wr_en;
  logic [63:0] base_wr_data;
  logic        xlate_en;
  logic [63:0] mem_size;
  logic        req_valid;
  logic [63:0] req_vaddr;
  logic        req_ready;
  logic        resp_valid;
  logic [63:0] resp_pte;
  logic        mem_rd_valid;
  logic [63:0] mem_rd_addr;
  logic        mem_rd_data_valid;
  logic [63:0] mem_rd_data;

  always #10 clk = ~clk;

  ptw_walker u_ptw_walker (
    .clk(clk), .rst(rst), .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
    .xlate_en(xlate_en), .mem_size(mem_size), .req_valid(req_valid),
    .req_vaddr(req_vaddr), .req_ready(req_ready), .resp_valid(resp_valid),
    .resp_pte(resp_pte), .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data_valid(mem_rd_data_valid), .mem_rd_data(mem_rd_data)
  );

  int checks = 0;
  int failures = 0;
  logic [63:0] mem_img [logic [63:0]];
  logic [63:0] exp_pte [$];
  string       exp_tag [$];
  logic [63:0] exp_addr [$];
  logic [63:0] tb_base;

  localparam logic [63:0] B1 = 64'h0010_0000;
  localparam logic [63:0] B2 = 64'h0020_0000;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] va_of(int i3, int i2, int i1, int i0, int off);
    return (64'(i3) << 39) | (64'(i2) << 30) | (64'(i1) << 21) | (64'(i0) << 12) | 64'(off);
  endfunction

  // bench model of the walk, taken from the requirements
  function automatic logic [63:0] model(logic [63:0] va, bit xen);
    logic [63:0] b;
    logic [63:0] a;
    logic [63:0] d;
    if (!xen)
      return {va[63:12], 2'b00, 6'h3F, 2'b00, 1'b1, (va < mem_size)};
    b = tb_base;
    d = '0;
    for (int lvl = 3; lvl >= 0; lvl--) begin
      a = b + (((va >> (12 + 9*lvl)) & 64'd511) << 3);
      if (a >= mem_size) return 64'd0;
      exp_addr.push_back(a);
      d = mem_img.exists(a) ? mem_img[a] : 64'd0;
      if (!d[0] || d[1]) return {d[63:1], d[0] & d[1]};
      b = {d[63:12], 12'd0};
    end
    return {d[63:1], 1'b0};
  endfunction

  task automatic wr_base(input logic [63:0] v);
    @(negedge clk);
    base_wr_en = 1'b1;
    base_wr_data = v;
    @(negedge clk);
    base_wr_en = 1'b0;
    tb_base = {v[63:12], 12'd0};
  endtask

  task automatic do_req(input logic [63:0] va, input string tag,
                        input bit wr_same, input logic [63:0] wr_val);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    exp_pte.push_back(model(va, xlate_en));
    exp_tag.push_back(tag);
    req_valid = 1'b1;
    req_vaddr = va;
    if (wr_same) begin
      base_wr_en = 1'b1;
      base_wr_data = wr_val;
    end
    @(negedge clk);
    req_valid = 1'b0;
    base_wr_en = 1'b0;
    if (wr_same) tb_base = {wr_val[63:12], 12'd0};
    check(req_ready == 1'b0, "R9 ready low after accept", 64'(req_ready), 64'd0);
    while (exp_pte.size() != 0) @(negedge clk);
    @(negedge clk);
    check(exp_addr.size() == 0, {tag, " R4 R8 read count"}, 64'(exp_addr.size()), 64'd0);
    exp_addr.delete();
  endtask

  // monitor: compare responses with the scoreboard
  always @(negedge clk) begin
    if (!rst && resp_valid) begin
      if (exp_pte.size() == 0) begin
        check(1'b0, "R9 unexpected response", resp_pte, 64'd0);
      end else begin
        logic [63:0] e;
        string t;
        e = exp_pte.pop_front();
        t = exp_tag.pop_front();
        check(resp_pte === e, t, resp_pte, e);
      end
    end
  end

  // memory responder: checks each read address, answers two cycles later
  initial begin
    mem_rd_data_valid = 1'b0;
    mem_rd_data = '0;
    forever begin
      @(negedge clk);
      if (!rst && mem_rd_valid) begin
        logic [63:0] a;
        a = mem_rd_addr;
        if (exp_addr.size() == 0) begin
          check(1'b0, "R3 R4 R8 unexpected read", a, 64'd0);
        end else begin
          logic [63:0] ea;
          ea = exp_addr.pop_front();
          check(a === ea, "R3 read address", a, ea);
        end
        repeat (2) @(negedge clk);
        mem_rd_data_valid = 1'b1;
        mem_rd_data = mem_img.exists(a) ? mem_img[a] : 64'd0;
        @(negedge clk);
        mem_rd_data_valid = 1'b0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", checks);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1;
    base_wr_en = 1'b0;
    base_wr_data = '0;
    xlate_en = 1'b1;
    mem_size = 64'h0100_0000;
    req_valid = 1'b0;
    req_vaddr = '0;
    tb_base = '0;

    // table 1
    mem_img[B1 + 8]            = (64'h101 << 12) | 64'h1;
    mem_img[64'h101000 + 16]   = (64'h102 << 12) | 64'h1;
    mem_img[64'h102000 + 24]   = (64'h103 << 12) | 64'h1;
    mem_img[64'h103000 + 32]   = (64'h555 << 12) | 64'h3F3;
    mem_img[64'h102000 + 40]   = (64'h200 << 12) | 64'h0AB;
    mem_img[B1 + 16]           = (64'h777 << 12) | 64'h3F3;
    mem_img[B1 + 24]           = (64'h999 << 12) | 64'h002;
    mem_img[B1 + 32]           = (64'h110 << 12) | 64'h1;
    mem_img[64'h110000]        = (64'h111 << 12) | 64'h1;
    mem_img[64'h111000]        = (64'h112 << 12) | 64'h1;
    mem_img[64'h112000]        = (64'hABC << 12) | 64'h1;
    mem_img[B1 + 40]           = (64'h2000 << 12) | 64'h1;
    // table 2
    mem_img[B2 + 16]           = (64'h888 << 12) | 64'h3F3;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
    check(resp_valid == 1'b0, "R1 no response after reset", 64'(resp_valid), 64'd0);
    check(mem_rd_valid == 1'b0, "R1 no read after reset", 64'(mem_rd_valid), 64'd0);

    // R2: unaligned write, walk must start at the aligned root
    wr_base(B1 | 64'hABC);
    do_req(va_of(1, 2, 3, 4, 'h123), "R2 R3 four-level leaf", 1'b0, '0);
    do_req(va_of(1, 2, 5, 7, 'h010), "R6 leaf at level 1", 1'b0, '0);
    do_req(va_of(2, 0, 0, 0, 'hFFF), "R6 leaf at level 3", 1'b0, '0);
    do_req(va_of(3, 9, 9, 9, 'h000), "R5 invalid entry", 1'b0, '0);
    do_req(va_of(0, 1, 1, 1, 'h000), "R5 empty entry", 1'b0, '0);
    do_req(va_of(4, 0, 0, 0, 'h044), "R7 non-leaf at level 0", 1'b0, '0);
    do_req(va_of(5, 3, 0, 0, 'h000), "R4 next entry out of range", 1'b0, '0);

    // R4: root itself out of range
    wr_base(64'h0200_0000);
    do_req(va_of(2, 0, 0, 0, 'h000), "R4 root out of range", 1'b0, '0);
    wr_base(B1);

    // R8: identity bypass
    xlate_en = 1'b0;
    do_req(64'h0012_3456, "R8 identity in range", 1'b0, '0);
    do_req(64'h0500_0000, "R8 identity out of range", 1'b0, '0);
    do_req(64'h00FF_FFFF, "R8 identity last byte", 1'b0, '0);
    xlate_en = 1'b1;

    // R10: base write in the accept cycle
    do_req(va_of(2, 0, 0, 0, 'h000), "R10 same-cycle write keeps old root", 1'b1, B2);
    do_req(va_of(2, 0, 0, 0, 'h000), "R10 new root used next", 1'b0, '0);
    wr_base(B1);

    // R10: base write during a four-level walk
    fork
      do_req(va_of(1, 2, 3, 4, 'h000), "R10 write during walk", 1'b0, '0);
      begin
        repeat (4) @(negedge clk);
        base_wr_en = 1'b1;
        base_wr_data = B2;
        @(negedge clk);
        base_wr_en = 1'b0;
      end
    join
    tb_base = B2;
    do_req(va_of(2, 0, 0, 0, 'h000), "R10 root after walk write", 1'b0, '0);

    repeat (3) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule